// File: doc/BRIEF.md
# Reset and Initialization Sequencer

This block is the reset controller of a peripheral controller. Several reset causes are merged into one chip-wide reset. They are a long enough pulse on an external reset pin, supply loss or an unsettled oscillator, a checksum error reported by the configuration-memory loader, a software reset bit, any change of the hardware standby or suspend inputs, and the exit from software suspend. The chip-wide reset stays asserted for a fixed hold time after the last cause goes away. A timed self-configuration phase follows, and status outputs report when it has finished.

Entering software suspend asserts a separate partial reset instead of the full one. The I/O base register and the self-control register keep their contents through it; every other register in its reach returns to its reset value. The block also holds the bus pointer register. After any reset that register reads a fixed signature word until software stores a nonzero value in it.

All time intervals are given in nanoseconds and converted to clock counts from a clock-frequency parameter. The pin qualification time, the init time and the hold length are parameters.

Top module: `rstseq_top`

## Requirements
- R1: `rst_pin` passes through a two-stage synchronizer. A high level lasting PIN_CYC consecutive clock samples (PIN_CYC = ceil(PIN_MIN_NS * CLK_HZ / 1e9)) asserts `full_rst` three edges after the last of those samples. A pulse one sample shorter has no effect.
- R2: While `pwr_good` is low, the block is asynchronously held in reset with `full_rst`=1, `initd`=0, `sibusy`=1 and all registers at their reset values. While `osc_stable` is low, `full_rst` stays asserted.
- R3: A one-cycle `eep_csum_err` asserts `full_rst` and clears `initd` on the next edge.
- R4: Writing `selfctl` with bit 6 set while `full_rst` is low starts a full reset. The written value reads back until the hold ends, and on that edge the register clears to 0. Writes to `selfctl` are ignored while `full_rst` is high.
- R5: Every rising or falling change of `hw_standby` or of `hw_suspend` asserts `full_rst` on the next edge.
- R6: While `sw_suspend` is high, `part_rst` is high from the next edge on. Writes to the pointer are ignored during this time, and the pointer returns to the signature. `selfctl` and `iobase` keep their values. A falling `sw_suspend` starts a full reset.
- R7: `full_rst` stays high for exactly HOLD_CYC cycles after the last edge at which any cause was present. A new cause restarts the count.
- R8: After `full_rst` falls, `initd`=0 and `sibusy`=1 hold for INIT_CYC cycles (INIT_CYC = ceil(INIT_NS * CLK_HZ / 1e9)). Then `initd`=1 and `sibusy`=0.
- R9: After a full or partial reset, `ptr_rdata` reads SIG_VALUE (default 16'h3000). Writes of zero keep the signature. After a nonzero write, the stored value is read back, including a later zero.
- R10: `iobase` loads IOBASE_RST (default 16'h0300) only on a full reset. It accepts writes when `full_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply good, low = asynchronous hold in reset |
| osc_stable | input | 1 | Oscillator settled |
| rst_pin | input | 1 | External reset pin, asynchronous |
| eep_csum_err | input | 1 | Checksum-error pulse from the configuration loader |
| hw_standby | input | 1 | Hardware standby level |
| hw_suspend | input | 1 | Hardware suspend level |
| sw_suspend | input | 1 | Software suspend level |
| selfctl_wr | input | 1 | Write strobe for the self-control register |
| iobase_wr | input | 1 | Write strobe for the I/O base register |
| ptr_wr | input | 1 | Write strobe for the bus pointer register |
| wr_data | input | DW | Write data shared by the three registers |
| full_rst | output | 1 | Chip-wide reset |
| part_rst | output | 1 | Partial reset for software suspend |
| initd | output | 1 | Initialization complete |
| sibusy | output | 1 | Self-configuration in progress |
| selfctl_rdata | output | DW | Self-control register value |
| iobase_rdata | output | DW | I/O base register value |
| ptr_rdata | output | DW | Bus pointer read value |

## Verification
Every output of the block is taken from a register. A cause sampled at edge k therefore shows on `full_rst` and `initd` after edge k, and a pin pulse shows three edges after its last sample. The release comes HOLD_CYC edges after the last cause, and `initd` rises a further INIT_CYC edges later. `part_rst` follows `sw_suspend` by one edge, and the pointer reaches the signature one edge after that. The bench drives its inputs just after a rising edge and reads the outputs half a period later. A behavioural model advanced on the same edges is compared with every output each cycle. Directed checks are placed at exact edge counts from the stimulus, for example the edge just before the release and the edge of the release itself.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [1:0] {
      PH_HOLD  = 2'd0,
      PH_INIT  = 2'd1,
      PH_READY = 2'd2
   } rs_phase_e;

   // ceiling of ns * hz / 1e9, in 64-bit arithmetic
   function automatic longint ns_to_cycles(input longint ns, input longint hz);
      return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/rstseq_pin_qual.sv
module rstseq_pin_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_CYC     = 50
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_async,
   output logic qual
);
   localparam int CW = $clog2(MIN_CYC + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          run_cnt;
   logic                   pin_hi;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rstseq_pin_qual: SYNC_STAGES must be at least 2");
      end
      if (MIN_CYC < 1) begin : g_bad_min
         $error("rstseq_pin_qual: MIN_CYC must be at least 1");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) sync_q[0] <= 1'b0;
               else         sync_q[0] <= pin_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) sync_q[i] <= 1'b0;
               else         sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   assign pin_hi = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                        run_cnt <= '0;
      else if (!pin_hi)                   run_cnt <= '0;
      else if (run_cnt != CW'(MIN_CYC))   run_cnt <= run_cnt + 1'b1;
   end

   assign qual = (run_cnt == CW'(MIN_CYC));

   // qualification only persists while the synchronized pin stays high
   assert_qual_drops_R1: assert property (@(posedge clk) disable iff (!arst_n)
      (qual && !pin_hi) |=> !qual);

endmodule

// File: rtl/rstseq_phase.sv
module rstseq_phase
   import rstseq_pkg::*;
#(
   parameter int HOLD_CYC = 16,
   parameter int INIT_CYC = 1000
) (
   input  logic clk,
   input  logic arst_n,
   input  logic trig,
   output logic full_rst,
   output logic initd,
   output logic sibusy,
   output logic hold_done
);
   localparam int MAXC = (HOLD_CYC > INIT_CYC) ? HOLD_CYC : INIT_CYC;
   localparam int TW   = $clog2(MAXC + 1);

   rs_phase_e       phase_q;
   logic [TW-1:0]   tmr_q;

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("rstseq_phase: HOLD_CYC must be at least 1");
      end
      if (INIT_CYC < 1) begin : g_bad_init
         $error("rstseq_phase: INIT_CYC must be at least 1");
      end
   endgenerate

   assign hold_done = (phase_q == PH_HOLD) && !trig && (tmr_q == TW'(HOLD_CYC - 1));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         phase_q <= PH_HOLD;
         tmr_q   <= '0;
      end else if (trig) begin
         phase_q <= PH_HOLD;
         tmr_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_HOLD: begin
               if (tmr_q == TW'(HOLD_CYC - 1)) begin
                  phase_q <= PH_INIT;
                  tmr_q   <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            PH_INIT: begin
               if (tmr_q == TW'(INIT_CYC - 1)) begin
                  phase_q <= PH_READY;
                  tmr_q   <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            default: tmr_q <= '0;
         endcase
      end
   end

   assign full_rst = (phase_q == PH_HOLD);
   assign initd    = (phase_q == PH_READY);
   assign sibusy   = (phase_q != PH_READY);

   assert_restart_R7: assert property (@(posedge clk) disable iff (!arst_n)
      trig |=> (full_rst && tmr_q == '0));

   assert_ready_from_init_R8: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(initd) |-> ($past(phase_q) == PH_INIT));

endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs #(
   parameter int             DW         = 16,
   parameter logic [DW-1:0]  SIG_VALUE  = 16'h3000,
   parameter logic [DW-1:0]  IOBASE_RST = 16'h0300
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          full_rst,
   input  logic          part_rst,
   input  logic          hold_done,
   input  logic          selfctl_wr,
   input  logic          iobase_wr,
   input  logic          ptr_wr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] selfctl_q,
   output logic [DW-1:0] iobase_q,
   output logic [DW-1:0] ptr_rdata
);
   logic          sig_q;
   logic [DW-1:0] ptr_q;

   // preserved through the partial reset: only the full reset touches these
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                       selfctl_q <= '0;
      else if (hold_done)                selfctl_q <= '0;
      else if (selfctl_wr && !full_rst)  selfctl_q <= wr_data;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)         iobase_q <= IOBASE_RST;
      else if (full_rst)   iobase_q <= IOBASE_RST;
      else if (iobase_wr)  iobase_q <= wr_data;
   end

   // pointer: signature until the first nonzero store
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         sig_q <= 1'b1;
         ptr_q <= '0;
      end else if (full_rst || part_rst) begin
         sig_q <= 1'b1;
         ptr_q <= '0;
      end else if (ptr_wr) begin
         ptr_q <= wr_data;
         if (wr_data != '0) sig_q <= 1'b0;
      end
   end

   assign ptr_rdata = sig_q ? SIG_VALUE : ptr_q;

   assert_iobase_keep_R10: assert property (@(posedge clk) disable iff (!arst_n)
      (!full_rst && !iobase_wr) |=> $stable(iobase_q));

   assert_ptr_store_R9: assert property (@(posedge clk) disable iff (!arst_n)
      (!full_rst && !part_rst && ptr_wr && wr_data != '0) |=> (ptr_rdata == $past(wr_data)));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int             DW          = 16,
   parameter longint         CLK_HZ      = 125_000_000,
   parameter int             PIN_MIN_NS  = 400,
   parameter int             INIT_NS     = 10_000_000,
   parameter int             HOLD_CYC    = 16,
   parameter int             SYNC_STAGES = 2,
   parameter int             SWRST_BIT   = 6,
   parameter logic [DW-1:0]  SIG_VALUE   = 16'h3000,
   parameter logic [DW-1:0]  IOBASE_RST  = 16'h0300
) (
   input  logic          clk,
   input  logic          pwr_good,
   input  logic          osc_stable,
   input  logic          rst_pin,
   input  logic          eep_csum_err,
   input  logic          hw_standby,
   input  logic          hw_suspend,
   input  logic          sw_suspend,
   input  logic          selfctl_wr,
   input  logic          iobase_wr,
   input  logic          ptr_wr,
   input  logic [DW-1:0] wr_data,
   output logic          full_rst,
   output logic          part_rst,
   output logic          initd,
   output logic          sibusy,
   output logic [DW-1:0] selfctl_rdata,
   output logic [DW-1:0] iobase_rdata,
   output logic [DW-1:0] ptr_rdata
);
   localparam int PIN_CYC  = int'(ns_to_cycles(longint'(PIN_MIN_NS), CLK_HZ));
   localparam int INIT_CYC = int'(ns_to_cycles(longint'(INIT_NS), CLK_HZ));

   generate
      if (SWRST_BIT >= DW) begin : g_bad_bit
         $error("rstseq_top: SWRST_BIT outside the data width");
      end
      if (CLK_HZ < 1) begin : g_bad_clk
         $error("rstseq_top: CLK_HZ must be positive");
      end
   endgenerate

   logic pin_qual, swrst_req, trig, hold_done;
   logic stb_q, sus_q, ssw_q;

   rstseq_pin_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_CYC     (PIN_CYC)
   ) u_pin (
      .clk       (clk),
      .arst_n    (pwr_good),
      .pin_async (rst_pin),
      .qual      (pin_qual)
   );

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         stb_q <= 1'b0;
         sus_q <= 1'b0;
         ssw_q <= 1'b0;
      end else begin
         stb_q <= hw_standby;
         sus_q <= hw_suspend;
         ssw_q <= sw_suspend;
      end
   end

   assign swrst_req = selfctl_wr && wr_data[SWRST_BIT] && !full_rst;

   assign trig = pin_qual || !osc_stable || eep_csum_err || swrst_req
              || (hw_standby != stb_q) || (hw_suspend != sus_q)
              || (ssw_q && !sw_suspend);

   assign part_rst = ssw_q;

   rstseq_phase #(
      .HOLD_CYC (HOLD_CYC),
      .INIT_CYC (INIT_CYC)
   ) u_phase (
      .clk       (clk),
      .arst_n    (pwr_good),
      .trig      (trig),
      .full_rst  (full_rst),
      .initd     (initd),
      .sibusy    (sibusy),
      .hold_done (hold_done)
   );

   rstseq_regs #(
      .DW         (DW),
      .SIG_VALUE  (SIG_VALUE),
      .IOBASE_RST (IOBASE_RST)
   ) u_regs (
      .clk        (clk),
      .arst_n     (pwr_good),
      .full_rst   (full_rst),
      .part_rst   (part_rst),
      .hold_done  (hold_done),
      .selfctl_wr (selfctl_wr),
      .iobase_wr  (iobase_wr),
      .ptr_wr     (ptr_wr),
      .wr_data    (wr_data),
      .selfctl_q  (selfctl_rdata),
      .iobase_q   (iobase_rdata),
      .ptr_rdata  (ptr_rdata)
   );

   assert_pin_reset_R1: assert property (@(posedge clk) disable iff (!pwr_good)
      pin_qual |=> full_rst);

   assert_osc_hold_R2: assert property (@(posedge clk) disable iff (!pwr_good)
      !osc_stable |=> full_rst);

   assert_eep_reset_R3: assert property (@(posedge clk) disable iff (!pwr_good)
      eep_csum_err |=> (full_rst && !initd));

   assert_swrst_R4: assert property (@(posedge clk) disable iff (!pwr_good)
      swrst_req |=> (full_rst && selfctl_rdata[SWRST_BIT]));

   assert_selfctl_clear_R4: assert property (@(posedge clk) disable iff (!pwr_good)
      $fell(full_rst) |-> (selfctl_rdata == '0));

   assert_hw_edge_R5: assert property (@(posedge clk) disable iff (!pwr_good)
      ((hw_standby != stb_q) || (hw_suspend != sus_q)) |=> full_rst);

   assert_part_sig_R6: assert property (@(posedge clk) disable iff (!pwr_good)
      part_rst |=> (ptr_rdata == SIG_VALUE));

endmodule

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
   localparam int DW       = 16;
   localparam int PIN_CYC  = 50;   // 400 ns at 125 MHz
   localparam int HOLD_CYC = 8;
   localparam int INIT_CYC = 250;  // 2000 ns at 125 MHz
   localparam logic [15:0] SIG = 16'h3000;
   localparam logic [15:0] IOB = 16'h0300;

   logic clk = 1'b0;
   logic pwr_good = 1'b0, osc_stable = 1'b0, rst_pin = 1'b0, eep_csum_err = 1'b0;
   logic hw_standby = 1'b0, hw_suspend = 1'b0, sw_suspend = 1'b0;
   logic selfctl_wr = 1'b0, iobase_wr = 1'b0, ptr_wr = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic full_rst, part_rst, initd, sibusy;
   logic [DW-1:0] selfctl_rdata, iobase_rdata, ptr_rdata;

   int n_chk = 0, n_fail = 0;
   bit cmp_en = 1'b0, ended = 1'b0;

   always #4 clk = ~clk;

   rstseq_top #(
      .DW (DW), .CLK_HZ (125_000_000), .PIN_MIN_NS (400), .INIT_NS (2000),
      .HOLD_CYC (HOLD_CYC), .SYNC_STAGES (2), .SWRST_BIT (6),
      .SIG_VALUE (SIG), .IOBASE_RST (IOB)
   ) u_rstseq_top (
      .clk (clk), .pwr_good (pwr_good), .osc_stable (osc_stable), .rst_pin (rst_pin),
      .eep_csum_err (eep_csum_err), .hw_standby (hw_standby), .hw_suspend (hw_suspend),
      .sw_suspend (sw_suspend), .selfctl_wr (selfctl_wr), .iobase_wr (iobase_wr),
      .ptr_wr (ptr_wr), .wr_data (wr_data), .full_rst (full_rst), .part_rst (part_rst),
      .initd (initd), .sibusy (sibusy), .selfctl_rdata (selfctl_rdata),
      .iobase_rdata (iobase_rdata), .ptr_rdata (ptr_rdata)
   );

   // behavioural reference: phase 0 = hold, 1 = init, 2 = ready
   int m_hist, m_run, m_ph, m_tmr;
   bit m_pstb, m_psus, m_pssw, m_sig;
   int m_self, m_io, m_ptr;
   int pin_q[$];

   task automatic model_reset();
      pin_q = {0, 0};
      m_run = 0; m_ph = 0; m_tmr = 0;
      m_pstb = 0; m_psus = 0; m_pssw = 0; m_sig = 1;
      m_self = 0; m_io = IOB; m_ptr = 0;
   endtask

   initial model_reset();

   always @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         model_reset();
      end else begin
         bit in_hold, cause, release_now;
         int synced;
         in_hold = (m_ph == 0);
         cause = (m_run >= PIN_CYC) || !osc_stable || eep_csum_err
              || (selfctl_wr && wr_data[6] && !in_hold)
              || (hw_standby != m_pstb) || (hw_suspend != m_psus)
              || (m_pssw && !sw_suspend);
         release_now = in_hold && !cause && (m_tmr == HOLD_CYC - 1);
         if (release_now) m_self = 0;
         else if (selfctl_wr && !in_hold) m_self = int'(wr_data);
         if (in_hold) m_io = IOB;
         else if (iobase_wr) m_io = int'(wr_data);
         if (in_hold || m_pssw) begin m_sig = 1; m_ptr = 0; end
         else if (ptr_wr) begin
            m_ptr = int'(wr_data);
            if (wr_data != 0) m_sig = 0;
         end
         if (cause) begin m_ph = 0; m_tmr = 0; end
         else if (m_ph < 2) begin
            if (m_tmr == ((m_ph == 0) ? HOLD_CYC : INIT_CYC) - 1) begin
               m_ph = m_ph + 1; m_tmr = 0;
            end else m_tmr = m_tmr + 1;
         end
         synced = pin_q.pop_front();
         m_run = (synced != 0) ? ((m_run < PIN_CYC) ? m_run + 1 : m_run) : 0;
         pin_q.push_back(int'(rst_pin));
         m_pstb = hw_standby; m_psus = hw_suspend; m_pssw = sw_suspend;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison, half a period after each rising edge
   always @(negedge clk) begin
      if (cmp_en && !ended) begin
         chk("R7 model full_rst", 32'(full_rst), 32'(m_ph == 0));
         chk("R8 model initd",    32'(initd),    32'(m_ph == 2));
         chk("R8 model sibusy",   32'(sibusy),   32'(m_ph != 2));
         chk("R6 model part_rst", 32'(part_rst), 32'(m_pssw));
         chk("R4 model selfctl",  32'(selfctl_rdata), 32'(m_self));
         chk("R10 model iobase",  32'(iobase_rdata),  32'(m_io));
         chk("R9 model pointer",  32'(ptr_rdata), m_sig ? 32'(SIG) : 32'(m_ptr));
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wait_ready();
      int k = 0;
      while (!initd && k < 2000) begin step(1); k++; end
      chk("R8 ready reached", 32'(initd), 32'd1);
   endtask

   task automatic wr(input int sel, input logic [15:0] d);
      wr_data = d;
      selfctl_wr = (sel == 0); iobase_wr = (sel == 1); ptr_wr = (sel == 2);
      step(1);
      selfctl_wr = 0; iobase_wr = 0; ptr_wr = 0; wr_data = '0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      step(3);
      cmp_en = 1'b1;
      // R2: supply low holds everything in reset
      chk("R2 full_rst in power-down", 32'(full_rst), 32'd1);
      chk("R2 sibusy in power-down", 32'(sibusy), 32'd1);
      chk("R2 pointer signature in power-down", 32'(ptr_rdata), 32'(SIG));
      pwr_good = 1'b1;
      step(10);
      chk("R2 oscillator unsettled keeps full_rst", 32'(full_rst), 32'd1);
      osc_stable = 1'b1;
      step(HOLD_CYC);
      chk("R8 init phase after release", 32'(sibusy), 32'd1);
      wait_ready();
      chk("R10 iobase default", 32'(iobase_rdata), 32'(IOB));

      // R9: signature until a nonzero store
      wr(2, 16'h0000);
      chk("R9 zero write keeps signature", 32'(ptr_rdata), 32'(SIG));
      wr(2, 16'h0123);
      chk("R9 nonzero write read back", 32'(ptr_rdata), 32'h0123);
      wr(2, 16'h0000);
      chk("R9 later zero read back", 32'(ptr_rdata), 32'h0000);

      // R1: a pulse one sample short is ignored
      rst_pin = 1'b1; step(PIN_CYC - 1); rst_pin = 1'b0;
      step(60);
      chk("R1 short pulse ignored", 32'(initd), 32'd1);
      // R1: a full-length pulse resets, three edges after its last sample
      rst_pin = 1'b1; step(PIN_CYC); rst_pin = 1'b0;
      step(2);
      chk("R1 not yet reset", 32'(full_rst), 32'd0);
      step(1);
      chk("R1 qualified pulse resets", 32'(full_rst), 32'd1);
      wait_ready();
      chk("R9 pointer back to signature", 32'(ptr_rdata), 32'(SIG));

      // R3 and R8 timing
      eep_csum_err = 1'b1; step(1); eep_csum_err = 1'b0;
      chk("R3 checksum error resets", 32'(full_rst), 32'd1);
      chk("R3 initd cleared", 32'(initd), 32'd0);
      step(HOLD_CYC - 1);
      chk("R7 still held on last hold cycle", 32'(full_rst), 32'd1);
      step(1);
      chk("R7 released after hold", 32'(full_rst), 32'd0);
      step(INIT_CYC - 1);
      chk("R8 initd low on last init cycle", 32'(initd), 32'd0);
      step(1);
      chk("R8 initd high after init", 32'(initd), 32'd1);
      chk("R8 sibusy low after init", 32'(sibusy), 32'd0);

      // R4: software reset bit and self-clear
      wr(0, 16'h0040);
      chk("R4 software reset asserted", 32'(full_rst), 32'd1);
      chk("R4 bit reads back during hold", 32'(selfctl_rdata), 32'h0040);
      wr(0, 16'h0005);
      chk("R4 write during hold ignored", 32'(selfctl_rdata), 32'h0040);
      step(HOLD_CYC - 2);
      chk("R4 bit still set before release", 32'(selfctl_rdata), 32'h0040);
      step(1);
      chk("R4 cleared at release", 32'(selfctl_rdata), 32'h0000);
      wait_ready();
      wr(0, 16'h0005);
      step(3);
      chk("R4 plain write no reset", 32'(full_rst), 32'd0);
      chk("R4 plain write stored", 32'(selfctl_rdata), 32'h0005);

      // R5: both directions of both hardware modes
      hw_standby = 1'b1; step(1);
      chk("R5 standby entry resets", 32'(full_rst), 32'd1);
      wait_ready();
      hw_standby = 1'b0; step(1);
      chk("R5 standby exit resets", 32'(full_rst), 32'd1);
      wait_ready();
      hw_suspend = 1'b1; step(1);
      chk("R5 suspend entry resets", 32'(full_rst), 32'd1);
      wait_ready();
      hw_suspend = 1'b0; step(1);
      chk("R5 suspend exit resets", 32'(full_rst), 32'd1);
      wait_ready();

      // R6 and R10: software suspend keeps the preserved registers
      wr(1, 16'h0360);
      wr(0, 16'h0011);
      wr(2, 16'h0055);
      sw_suspend = 1'b1; step(1);
      chk("R6 partial reset asserted", 32'(part_rst), 32'd1);
      chk("R6 no full reset on entry", 32'(full_rst), 32'd0);
      step(1);
      chk("R6 pointer to signature", 32'(ptr_rdata), 32'(SIG));
      chk("R10 iobase kept in suspend", 32'(iobase_rdata), 32'h0360);
      chk("R6 selfctl kept in suspend", 32'(selfctl_rdata), 32'h0011);
      wr(2, 16'h0077);
      chk("R6 pointer write ignored in suspend", 32'(ptr_rdata), 32'(SIG));
      sw_suspend = 1'b0; step(1);
      chk("R6 suspend exit full reset", 32'(full_rst), 32'd1);
      step(1);
      chk("R10 iobase default after full reset", 32'(iobase_rdata), 32'(IOB));
      wait_ready();

      // R7: repeated causes restart the hold
      eep_csum_err = 1'b1; step(1); eep_csum_err = 1'b0;
      step(5);
      eep_csum_err = 1'b1; step(1); eep_csum_err = 1'b0;
      step(HOLD_CYC - 1);
      chk("R7 hold restarted by later cause", 32'(full_rst), 32'd1);
      step(1);
      chk("R7 release after restarted hold", 32'(full_rst), 32'd0);
      wait_ready();

      // R2: supply loss from the ready state
      pwr_good = 1'b0; step(1);
      chk("R2 supply loss resets", 32'(full_rst), 32'd1);
      chk("R2 supply loss clears initd", 32'(initd), 32'd0);
      step(2);
      finish_run();
   end

endmodule